// File: doc/BRIEF.md
# DES Round-Key Generator

This block produces the sixteen 48-bit round keys of the DES cipher one at a time, as the cipher datapath asks for them, and keeps no table of precomputed keys. A 64-bit key word is captured on a load strobe. The eight parity bits are dropped and the remaining 56 bits are rearranged into two 28-bit halves. Each half sits in its own rotating register. A fixed selection network reads 48 of the 56 register bits to form the current round key.

One pair of rotating registers serves both cipher directions. For encryption the halves turn left, and the schedule's per-round amount is applied between rounds. For decryption the halves turn right by the same amounts taken in reverse round order, so the keys appear last-to-first. The direction is captured together with the key, and each advance strobe steps to the next key. After the sixteenth key the valid flag falls and stays low until the next load.

Top module: `des_round_key_gen`

## Requirements
- R1: While reset is held and after it is released, `rk_valid_o` is 0 and `rk_o` is all zeros until the first load.
- R2: A load in cycle N makes the first round key of the selected direction visible with `rk_valid_o`=1 after the clock edge ending cycle N. A load takes precedence over a simultaneous advance and restarts the sequence, even in the middle of a block.
- R3: Key bit 1 (the first bit of the standard numbering) is `key_i[63]`. Standard bit n is `key_i[64-n]`. The parity bits (standard bits 8, 16, ..., 64, which are `key_i[56]`, `key_i[48]`, ..., `key_i[0]`) have no effect on any round key.
- R4: In encrypt direction, round key r is taken after both halves have turned left by the cumulative schedule amount. Rounds 1, 2, 9 and 16 contribute one position each, and every other round contributes two.
- R5: Each round key is the standard 48-of-56 selection of the concatenated halves, with the first selected bit on `rk_o[47]`. For key 133457799BBCDFF1 (hex), encrypt round 1 gives 1B02EFFC7072 and round 16 gives CB3D8B0E17F5.
- R6: In decrypt direction (`decrypt_i`=1 at load), the k-th key presented equals encrypt round key 17-k. The first key presented equals the encrypt round-16 key and needs no rotation of the loaded halves.
- R7: Exactly 16 keys are produced per load. The advance that follows the 16th key drops `rk_valid_o` to 0 and `rk_o` to zeros, and further advances have no effect until the next load.
- R8: In a cycle without load or advance, the presented round key and the valid flag stay unchanged.
- R9: The direction is sampled only at load. Changing `decrypt_i` between loads does not alter the key sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture `key_i` and `decrypt_i` and restart at the first key |
| key_i | input | 64 | Key word including parity bits |
| decrypt_i | input | 1 | Direction for the next load: 1 decrypt, 0 encrypt |
| advance_i | input | 1 | Step to the next round key |
| rk_o | output | 48 | Current round key, zero while not valid |
| rk_valid_o | output | 1 | Round key on `rk_o` is valid |

## Verification
The assertions rely on `load_i`, `advance_i` and `decrypt_i` having known values at every clock edge after reset. They also rely on the direction and key matching the cycle in which the load is sampled, and on nothing else, such as strobe pulse width or spacing. The stimulus changes every input on the falling edge only and holds it steady through the rising edge. It uses back-to-back advances, sparse advances, advances issued after the sequence has ended, and a load that coincides with an advance. A scoreboard model built from the requirements, not from the register structure, predicts every cycle's output.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;

   localparam int KEY_W  = 64;
   localparam int SEL_W  = 56;
   localparam int HALF_W = 28;
   localparam int RK_W   = 48;

   // first selection: index (1-based, MSB first) of the key bit for each output bit
   localparam int unsigned CHOICE1 [SEL_W] = '{
      57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
      10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
      63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
      14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

   // second selection: index (1-based, MSB first) into the 56 half bits
   localparam int unsigned CHOICE2 [RK_W] = '{
      14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
      23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
      41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
      44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

   function automatic logic [SEL_W-1:0] pick_halves(input logic [KEY_W-1:0] k);
      logic [SEL_W-1:0] r;
      for (int j = 0; j < SEL_W; j++) begin
         r[SEL_W-1-j] = k[KEY_W - int'(CHOICE1[j])];
      end
      return r;
   endfunction

   function automatic logic [RK_W-1:0] pick_round(input logic [SEL_W-1:0] h);
      logic [RK_W-1:0] r;
      for (int j = 0; j < RK_W; j++) begin
         r[RK_W-1-j] = h[SEL_W - int'(CHOICE2[j])];
      end
      return r;
   endfunction

   function automatic int ones_in(input logic [63:0] v, input int n);
      int c;
      c = 0;
      for (int i = 0; i < n; i++) begin
         if (v[i]) c++;
      end
      return c;
   endfunction

endpackage

// File: rtl/des_ks_select.sv
module des_ks_select #(
   parameter int IN_W  = 64,
   parameter int OUT_W = 56,
   parameter bit FIRST = 1'b1
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   import des_ks_pkg::*;

   generate
      if (FIRST) begin : g_first
         if (IN_W != KEY_W || OUT_W != SEL_W) begin : g_bad
            $error("first selection needs %0d in, %0d out", KEY_W, SEL_W);
         end
         logic [KEY_W-1:0] wide;
         assign wide = KEY_W'(din);
         assign dout = OUT_W'(pick_halves(wide));
      end else begin : g_second
         if (IN_W != SEL_W || OUT_W != RK_W) begin : g_bad
            $error("second selection needs %0d in, %0d out", SEL_W, RK_W);
         end
         logic [SEL_W-1:0] wide;
         assign wide = SEL_W'(din);
         assign dout = OUT_W'(pick_round(wide));
      end
   endgenerate

endmodule

// File: rtl/des_ks_half.sv
module des_ks_half #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         load_rot_i,
   input  logic         load_two_i,
   input  logic         step_i,
   input  logic         right_i,
   input  logic         two_i,
   output logic [W-1:0] q_o
);

   if (W < 3) begin : g_bad
      $error("half width must be at least 3");
   end

   logic [W-1:0] q;
   logic [W-1:0] src;
   logic [W-1:0] turned;
   logic [W-1:0] nxt;
   logic         do_rot;
   logic         go_right;
   logic         go_two;

   // one rotator shared between load-time pre-rotation and round steps
   always_comb begin
      src      = load_i ? load_val_i : q;
      do_rot   = load_i ? load_rot_i : step_i;
      go_right = load_i ? 1'b0       : right_i;
      go_two   = load_i ? load_two_i : two_i;
      case ({go_right, go_two})
         2'b00:   turned = {src[W-2:0], src[W-1]};
         2'b01:   turned = {src[W-3:0], src[W-1:W-2]};
         2'b10:   turned = {src[0], src[W-1:1]};
         default: turned = {src[1:0], src[W-1:2]};
      endcase
      nxt = do_rot ? turned : src;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load_i || step_i) begin
         q <= nxt;
      end
   end

   assign q_o = q;

   AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_i) |=> $stable(q_o)); // R8

   AST_HALF_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> ($countones(q_o) == $countones($past(q_o)))); // R4

endmodule

// File: rtl/des_ks_seq.sv
module des_ks_seq #(
   parameter int               ROUNDS   = 16,
   parameter logic [ROUNDS-1:0] ONE_MASK = 16'h8103
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic dec_i,
   input  logic adv_i,
   output logic valid_o,
   output logic dec_o,
   output logic step_o,
   output logic two_o,
   output logic load_two_o
);

   localparam int              CW   = (ROUNDS > 2) ? $clog2(ROUNDS) : 1;
   localparam logic [CW-1:0]   LAST = CW'(ROUNDS - 1);

   if (ROUNDS < 2) begin : g_bad
      $error("at least two rounds required");
   end

   logic [CW-1:0] cnt_q;
   logic          valid_q;
   logic          dec_q;
   logic [CW-1:0] nidx;

   // schedule index of the rotation that leads to the next key
   always_comb begin
      nidx   = dec_q ? (LAST - cnt_q) : (cnt_q + 1'b1);
      step_o = adv_i && valid_q && !load_i && (cnt_q != LAST);
      two_o  = !ONE_MASK[nidx];
   end

   assign load_two_o = !ONE_MASK[0];
   assign valid_o    = valid_q;
   assign dec_o      = dec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
         dec_q   <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= '0;
         valid_q <= 1'b1;
         dec_q   <= dec_i;
      end else if (adv_i && valid_q) begin
         if (cnt_q == LAST) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (valid_o && cnt_q == '0)); // R2

   AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && adv_i && !load_i && cnt_q == LAST) |=> !valid_o); // R7

   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !load_i) |=> !valid_o); // R7

   AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(dec_o)); // R9

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4

endmodule

// File: rtl/des_round_key_gen.sv
module des_round_key_gen #(
   parameter int                ROUNDS         = 16,
   parameter logic [ROUNDS-1:0] SHIFT_ONE_MASK = 16'h8103,
   parameter bit                ZERO_WHEN_IDLE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_i,
   input  logic [des_ks_pkg::KEY_W-1:0] key_i,
   input  logic                      decrypt_i,
   input  logic                      advance_i,
   output logic [des_ks_pkg::RK_W-1:0]  rk_o,
   output logic                      rk_valid_o
);
   import des_ks_pkg::*;

   localparam int TOTAL_TURN = 2 * ROUNDS - ones_in(64'(SHIFT_ONE_MASK), ROUNDS);

   // decrypt relies on the full schedule returning the halves to their start
   if ((TOTAL_TURN % HALF_W) != 0) begin : g_bad_sched
      $error("schedule total %0d is not a multiple of %0d", TOTAL_TURN, HALF_W);
   end

   logic [SEL_W-1:0]  loaded;
   logic [HALF_W-1:0] c_q;
   logic [HALF_W-1:0] d_q;
   logic [RK_W-1:0]   picked;
   logic              valid;
   logic              dec;
   logic              step;
   logic              two;
   logic              load_two;

   des_ks_select #(.IN_W(KEY_W), .OUT_W(SEL_W), .FIRST(1'b1)) u_first (
      .din  (key_i),
      .dout (loaded)
   );

   des_ks_seq #(.ROUNDS(ROUNDS), .ONE_MASK(SHIFT_ONE_MASK)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .dec_i      (decrypt_i),
      .adv_i      (advance_i),
      .valid_o    (valid),
      .dec_o      (dec),
      .step_o     (step),
      .two_o      (two),
      .load_two_o (load_two)
   );

   des_ks_half #(.W(HALF_W)) u_c (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_val_i (loaded[SEL_W-1:HALF_W]),
      .load_rot_i (!decrypt_i),
      .load_two_i (load_two),
      .step_i     (step),
      .right_i    (dec),
      .two_i      (two),
      .q_o        (c_q)
   );

   des_ks_half #(.W(HALF_W)) u_d (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_val_i (loaded[HALF_W-1:0]),
      .load_rot_i (!decrypt_i),
      .load_two_i (load_two),
      .step_i     (step),
      .right_i    (dec),
      .two_i      (two),
      .q_o        (d_q)
   );

   des_ks_select #(.IN_W(SEL_W), .OUT_W(RK_W), .FIRST(1'b0)) u_second (
      .din  ({c_q, d_q}),
      .dout (picked)
   );

   generate
      if (ZERO_WHEN_IDLE) begin : g_gate
         assign rk_o = valid ? picked : '0;
      end else begin : g_raw
         assign rk_o = picked;
      end
   endgenerate

   assign rk_valid_o = valid;

   AST_DEC_UNTURNED: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && decrypt_i) |=> ({c_q, d_q} == $past(loaded))); // R6

   AST_ENC_TURNED: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !decrypt_i) |=> (c_q == {$past(loaded[SEL_W-2:HALF_W]), $past(loaded[SEL_W-1])})); // R4

endmodule

// File: tb/des_round_key_gen_bench.sv
module des_round_key_gen_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [63:0] key_i = '0;
   logic        decrypt_i = 1'b0;
   logic        advance_i = 1'b0;
   logic [47:0] rk_o;
   logic        rk_valid_o;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   des_round_key_gen u_des_round_key_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .key_i      (key_i),
      .decrypt_i  (decrypt_i),
      .advance_i  (advance_i),
      .rk_o       (rk_o),
      .rk_valid_o (rk_valid_o)
   );

   // reference tables written from the standard key schedule
   int unsigned t1 [56] = '{
      57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,60,52,44,36,
      63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
   int unsigned t2 [48] = '{
      14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
      41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};

   // encrypt round key r (1..16) from cumulative left turns
   function automatic logic [47:0] model_key(input logic [63:0] k, input int r);
      logic [27:0] c, d;
      logic [55:0] h;
      logic [47:0] o;
      int turns;
      for (int j = 0; j < 56; j++) h[55-j] = k[64 - int'(t1[j])];
      c = h[55:28];
      d = h[27:0];
      turns = 0;
      for (int i = 1; i <= r; i++) turns += (i == 1 || i == 2 || i == 9 || i == 16) ? 1 : 2;
      for (int s = 0; s < turns; s++) begin
         c = {c[26:0], c[27]};
         d = {d[26:0], d[27]};
      end
      h = {c, d};
      for (int j = 0; j < 48; j++) o[47-j] = h[56 - int'(t2[j])];
      return o;
   endfunction

   // scoreboard
   logic [48:0] exp_q [$];
   string       tag_q [$];

   logic        m_valid = 1'b0;
   int          m_cnt   = 0;
   logic        m_dec   = 1'b0;
   logic [63:0] m_key   = '0;

   task automatic check(input string tag, input logic gv, input logic [47:0] gk,
                        input logic ev, input logic [47:0] ek);
      checks++;
      if (gv !== ev || gk !== ek) begin
         fails++;
         $display("FAIL %s: got valid=%0b key=%h, expected valid=%0b key=%h", tag, gv, gk, ev, ek);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [48:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, rk_valid_o, rk_o, e[48], e[47:0]);
      end
   end

   // drive one cycle and push the expected result after its rising edge
   task automatic cyc(input logic ld, input logic [63:0] k, input logic dec, input logic adv,
                      input string tag, input bit fixed = 1'b0, input logic [47:0] want = '0);
      logic [47:0] ek;
      @(negedge clk);
      load_i    = ld;
      key_i     = k;
      decrypt_i = dec;
      advance_i = adv;
      if (ld) begin
         m_valid = 1'b1; m_cnt = 0; m_dec = dec; m_key = k;
      end else if (adv && m_valid) begin
         if (m_cnt == 15) begin m_valid = 1'b0; m_cnt = 0; end
         else m_cnt++;
      end
      if (!m_valid)      ek = '0;
      else if (m_dec)    ek = model_key(m_key, 16 - m_cnt);
      else               ek = model_key(m_key, m_cnt + 1);
      if (fixed) ek = want;
      exp_q.push_back({m_valid, ek});
      tag_q.push_back(tag);
   endtask

   task automatic full_block(input logic [63:0] k, input logic dec, input string tag);
      cyc(1'b1, k, dec, 1'b0, tag);
      for (int i = 0; i < 16; i++) cyc(1'b0, k, dec, 1'b1, tag);
      cyc(1'b0, k, dec, 1'b1, {tag, " R7 after end"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [63:0] k1, k2, k3, kr;
      k1 = 64'h133457799BBCDFF1;
      k2 = 64'h0E329232EA6D0D73;
      k3 = 64'hA5F00FC3_3C96E187;

      repeat (3) @(posedge clk);
      #2;
      check("R1 in reset", rk_valid_o, rk_o, 1'b0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check("R1 after reset", rk_valid_o, rk_o, 1'b0, '0);
      cyc(1'b0, k1, 1'b0, 1'b1, "R1 advance before load");

      // encrypt known vector
      cyc(1'b1, k1, 1'b0, 1'b0, "R2 R5 encrypt round 1", 1'b1, 48'h1B02EFFC7072);
      for (int i = 0; i < 14; i++) cyc(1'b0, k1, 1'b0, 1'b1, "R4 R5 encrypt step");
      cyc(1'b0, k1, 1'b0, 1'b1, "R5 encrypt round 16", 1'b1, 48'hCB3D8B0E17F5);
      cyc(1'b0, k1, 1'b0, 1'b1, "R7 drop after 16");
      cyc(1'b0, k1, 1'b0, 1'b1, "R7 advance ignored");
      cyc(1'b0, k1, 1'b1, 1'b1, "R7 advance ignored");

      // decrypt known vector
      cyc(1'b1, k1, 1'b1, 1'b0, "R6 decrypt first", 1'b1, 48'hCB3D8B0E17F5);
      for (int i = 0; i < 14; i++) cyc(1'b0, k1, 1'b0, 1'b1, "R6 decrypt step");
      cyc(1'b0, k1, 1'b1, 1'b1, "R6 decrypt last", 1'b1, 48'h1B02EFFC7072);
      cyc(1'b0, k1, 1'b1, 1'b1, "R7 decrypt drop");

      // sparse advances with direction toggling between loads
      cyc(1'b1, k2, 1'b0, 1'b0, "R2 load k2");
      for (int i = 0; i < 60; i++)
         cyc(1'b0, k2 ^ {64{i[1]}}, i[0], (i % 3 == 0), "R8 R9 sparse advance");

      // parity bits flipped must not matter: model keeps original key
      cyc(1'b1, k2 ^ 64'h0101010101010101, 1'b1, 1'b0, "R3 parity flip load");
      m_key = k2;
      for (int i = 0; i < 16; i++) cyc(1'b0, k2, 1'b1, 1'b1, "R3 parity flip step");

      // restart mid-block with advance high
      cyc(1'b1, k3, 1'b0, 1'b0, "R2 load k3");
      for (int i = 0; i < 5; i++) cyc(1'b0, k3, 1'b0, 1'b1, "R4 k3 step");
      cyc(1'b1, k1, 1'b1, 1'b1, "R2 reload wins over advance", 1'b1, 48'hCB3D8B0E17F5);
      cyc(1'b0, k1, 1'b0, 1'b0, "R8 hold");
      cyc(1'b0, k1, 1'b0, 1'b0, "R8 hold");

      // key sweep in both directions
      kr = 64'h0123456789ABCDEF;
      for (int n = 0; n < 6; n++) begin
         kr = {kr[62:0], kr[63] ^ kr[62] ^ kr[60] ^ kr[59]} ^ 64'h9E3779B97F4A7C15;
         full_block(kr, n[0], "R4 R6 sweep");
      end

      wait (exp_q.size() == 0);
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule